// File: doc/BRIEF.md
# Host Command Packet Responder

This block sits behind a byte-level host transport and acts on whole packets that the transport has already gathered into a buffer. It checks the leading class byte. Control packets are decoded against a fixed command set, and each one is answered with a reply packet. Packets for the peripheral bus are passed on as a single request strobe, together with their payload. Any other class is dropped.

The block holds a small amount of system state. This is a free-running seconds counter, an auto-poll enable, a poll period in milliseconds and a 16-bit device poll mask. The last three are brought out as levels for an external poll engine. When polling is enabled, that engine hands back poll data, and the block wraps it into an asynchronous reply. Power-off and restart commands are acknowledged first. Each one then fires a one-cycle pulse on its own output.

A request with the wrong number of argument bytes gets an error reply with a distinct code. So does an unknown command code.

Top module: `host_cmd_responder`

## Requirements
- R1: After reset the poll period is 20, the poll mask is 0xFFFF, auto-poll is off, and no reply, bus request or pulse is active.
- R2: Packet byte 0 (bits 7:0 of `pkt_data`) is the class. Class 0 raises `bus_req` for one cycle, with the length reduced by one and the bytes after the class. Any class other than 0 or 1, and a class-1 packet shorter than two bytes, produce no reply and no request.
- R3: A valid class-1 packet with command byte C (byte 1) gives a reply in the cycle after it is accepted. A success reply is {0x01, 0x00, C} followed by any result bytes. Reply byte i is `rep_data[8i+7:8i]`.
- R4: Command 0x03 with no arguments replies with length 7, carrying the 32-bit seconds value most significant byte first.
- R5: Command 0x09 with four arguments loads the seconds value from them, most significant first. The value then increases by one every SEC_TICKS clock cycles.
- R6: Command 0x01 with one argument sets auto-poll on if the argument is nonzero and off if it is zero.
- R7: Command 0x14 with one argument sets the poll period. An argument of zero is rejected with the bad-argument error and leaves the period unchanged.
- R8: Command 0x19 with two arguments sets the poll mask to (first << 8) | second.
- R9: A known command with the wrong argument count replies {0x02, 0x05, 0x01, C} with length 4 and changes no state.
- R10: An unknown command replies {0x02, 0x02, 0x01, C} with length 4.
- R11: Commands 0x0A and 0x11 with no arguments give a success reply. In the cycle after that reply, they pulse `power_off_pulse` or `restart_pulse` for one cycle.
- R12: Commands 0x13 and 0x21 with one argument give a success reply and change no other state.
- R13: With auto-poll on, poll data of n bytes produces the reply {0x00, 0x40, data} with length n+2. With auto-poll off, poll data is ignored.
- R14: When a command reply and poll data arrive in the same cycle, the command reply goes out first and the poll reply follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Received packet present this cycle |
| pkt_len | input | IN_LW | Packet length in bytes |
| pkt_data | input | IN_BYTES*8 | Packet bytes, byte 0 in bits 7:0 |
| poll_valid | input | 1 | Poll data present this cycle |
| poll_len | input | PL_W | Poll data length in bytes |
| poll_data | input | POLL_BYTES*8 | Poll bytes, byte 0 in bits 7:0 |
| rep_valid | output | 1 | Reply packet present this cycle |
| rep_len | output | OUT_LW | Reply length in bytes |
| rep_data | output | OUT_BYTES*8 | Reply bytes, byte 0 in bits 7:0 |
| bus_req | output | 1 | Peripheral-bus request strobe |
| bus_len | output | IN_LW | Request length in bytes |
| bus_data | output | (IN_BYTES-1)*8 | Request bytes, class byte removed |
| poll_enable | output | 1 | Auto-poll enable |
| poll_period_ms | output | 8 | Poll period in milliseconds |
| poll_mask | output | 16 | Device poll mask |
| power_off_pulse | output | 1 | One-cycle power-off request |
| restart_pulse | output | 1 | One-cycle restart request |

## Verification
A command reply and an asynchronous poll reply compete for the single reply output. The bench provokes this by driving a control packet and poll data on the same clock edge while auto-poll is on. The scoreboard expects the command reply first and the poll reply, with its original bytes, in the very next cycle. A dropped, merged or reordered reply is caught as a mismatch or as an unexpected entry.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    // packet classes
    localparam logic [7:0] CLS_BUS = 8'h00;
    localparam logic [7:0] CLS_CTL = 8'h01;
    localparam logic [7:0] CLS_ERR = 8'h02;

    // error codes and poll tag
    localparam logic [7:0] ERR_UNKNOWN = 8'h02;
    localparam logic [7:0] ERR_BADARG  = 8'h05;
    localparam logic [7:0] POLL_TAG    = 8'h40;

    // control opcodes
    localparam logic [7:0] OP_AUTOPOLL  = 8'h01;
    localparam logic [7:0] OP_GET_TIME  = 8'h03;
    localparam logic [7:0] OP_SET_TIME  = 8'h09;
    localparam logic [7:0] OP_POWER_OFF = 8'h0A;
    localparam logic [7:0] OP_RESTART   = 8'h11;
    localparam logic [7:0] OP_FS_FLAG   = 8'h13;
    localparam logic [7:0] OP_SET_RATE  = 8'h14;
    localparam logic [7:0] OP_SET_MASK  = 8'h19;
    localparam logic [7:0] OP_PWR_MSG   = 8'h21;

    typedef struct packed {
        logic       known;
        logic [2:0] nargs;
    } op_info_t;

    typedef struct packed {
        logic        set_poll_en;
        logic        poll_en;
        logic        set_rate;
        logic [7:0]  rate;
        logic        set_mask;
        logic [15:0] mask;
        logic        set_secs;
        logic [31:0] secs;
        logic        power_off;
        logic        restart;
    } effect_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CMD,
        SRC_POLL_NEW,
        SRC_POLL_HELD
    } src_e;

    function automatic op_info_t op_lookup(input logic [7:0] c);
        op_info_t o;
        o.known = 1'b1;
        case (c)
            OP_GET_TIME, OP_POWER_OFF, OP_RESTART:          o.nargs = 3'd0;
            OP_AUTOPOLL, OP_FS_FLAG, OP_SET_RATE, OP_PWR_MSG: o.nargs = 3'd1;
            OP_SET_MASK:                                   o.nargs = 3'd2;
            OP_SET_TIME:                                   o.nargs = 3'd4;
            default: begin
                o.known = 1'b0;
                o.nargs = 3'd0;
            end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/rsp_sec_counter.sv
module rsp_sec_counter #(
    parameter int SEC_TICKS = 50_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] load_val,
    output logic [31:0] secs
);
    localparam int TW = (SEC_TICKS > 1) ? $clog2(SEC_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(SEC_TICKS - 1);

    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= '0;
            secs <= '0;
        end else if (load) begin
            tick <= '0;
            secs <= load_val;
        end else if (tick == LAST) begin
            tick <= '0;
            secs <= secs + 32'd1;
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/rsp_cmd_decode.sv
module rsp_cmd_decode
    import rsp_pkg::*;
#(
    parameter int IN_BYTES  = 8,
    parameter int OUT_BYTES = 10,
    parameter int IN_LW     = 4,
    parameter int OUT_LW    = 4
) (
    input  logic                   pkt_valid,
    input  logic [IN_LW-1:0]       pkt_len,
    input  logic [IN_BYTES*8-1:0]  pkt_data,
    input  logic [31:0]            secs,
    output logic                   has_reply,
    output logic [OUT_LW-1:0]      rep_len,
    output logic [OUT_BYTES*8-1:0] rep_flat,
    output logic                   fwd,
    output effect_t                fx
);
    logic [7:0] b [IN_BYTES];
    logic [7:0] r [OUT_BYTES];
    logic [IN_LW-1:0] argc;
    op_info_t info;

    for (genvar i = 0; i < IN_BYTES; i++) begin : g_unpack
        assign b[i] = pkt_data[8*i +: 8];
    end
    for (genvar j = 0; j < OUT_BYTES; j++) begin : g_pack
        assign rep_flat[8*j +: 8] = r[j];
    end

    always_comb begin
        for (int k = 0; k < OUT_BYTES; k++) r[k] = 8'h00;
        has_reply = 1'b0;
        rep_len   = '0;
        fwd       = 1'b0;
        fx        = '0;
        info      = op_lookup(b[1]);
        argc      = pkt_len - IN_LW'(2);
        if (pkt_valid && pkt_len != '0 && b[0] == CLS_BUS) begin
            fwd = 1'b1;
        end else if (pkt_valid && pkt_len >= IN_LW'(2) && b[0] == CLS_CTL) begin
            has_reply = 1'b1;
            if (!info.known) begin
                r[0] = CLS_ERR; r[1] = ERR_UNKNOWN; r[2] = CLS_CTL; r[3] = b[1];
                rep_len = OUT_LW'(4);
            end else if (argc != IN_LW'(info.nargs) ||
                         (b[1] == OP_SET_RATE && b[2] == 8'h00)) begin
                r[0] = CLS_ERR; r[1] = ERR_BADARG; r[2] = CLS_CTL; r[3] = b[1];
                rep_len = OUT_LW'(4);
            end else begin
                r[0] = CLS_CTL; r[1] = 8'h00; r[2] = b[1];
                rep_len = OUT_LW'(3);
                case (b[1])
                    OP_AUTOPOLL: begin
                        fx.set_poll_en = 1'b1;
                        fx.poll_en     = (b[2] != 8'h00);
                    end
                    OP_GET_TIME: begin
                        r[3] = secs[31:24]; r[4] = secs[23:16];
                        r[5] = secs[15:8];  r[6] = secs[7:0];
                        rep_len = OUT_LW'(7);
                    end
                    OP_SET_TIME: begin
                        fx.set_secs = 1'b1;
                        fx.secs     = {b[2], b[3], b[4], b[5]};
                    end
                    OP_POWER_OFF: fx.power_off = 1'b1;
                    OP_RESTART:   fx.restart   = 1'b1;
                    OP_SET_RATE: begin
                        fx.set_rate = 1'b1;
                        fx.rate     = b[2];
                    end
                    OP_SET_MASK: begin
                        fx.set_mask = 1'b1;
                        fx.mask     = {b[2], b[3]};
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rsp_reply_sel.sv
module rsp_reply_sel
    import rsp_pkg::*;
#(
    parameter int OUT_BYTES  = 10,
    parameter int OUT_LW     = 4,
    parameter int POLL_BYTES = 8,
    parameter int PL_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_has,
    input  logic [OUT_LW-1:0]       cmd_len,
    input  logic [OUT_BYTES*8-1:0]  cmd_flat,
    input  logic                    poll_take,
    input  logic [PL_W-1:0]         poll_len,
    input  logic [POLL_BYTES*8-1:0] poll_data,
    output logic                    rep_valid,
    output logic [OUT_LW-1:0]       rep_len,
    output logic [OUT_BYTES*8-1:0]  rep_data
);
    localparam int OUT_W = OUT_BYTES * 8;

    src_e                    src;
    logic                    held_v;
    logic [PL_W-1:0]         held_len;
    logic [POLL_BYTES*8-1:0] held_data;
    logic [OUT_LW-1:0]       p_len;
    logic [OUT_W-1:0]        p_flat;

    always_comb begin
        if (cmd_has)        src = SRC_CMD;
        else if (held_v)    src = SRC_POLL_HELD;
        else if (poll_take) src = SRC_POLL_NEW;
        else                src = SRC_NONE;
        if (src == SRC_POLL_HELD) begin
            p_len  = OUT_LW'(held_len) + OUT_LW'(2);
            p_flat = OUT_W'({held_data, POLL_TAG, CLS_BUS});
        end else begin
            p_len  = OUT_LW'(poll_len) + OUT_LW'(2);
            p_flat = OUT_W'({poll_data, POLL_TAG, CLS_BUS});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_valid <= 1'b0;
            rep_len   <= '0;
            rep_data  <= '0;
            held_v    <= 1'b0;
            held_len  <= '0;
            held_data <= '0;
        end else begin
            rep_valid <= (src != SRC_NONE);
            case (src)
                SRC_CMD: begin
                    rep_len  <= cmd_len;
                    rep_data <= cmd_flat;
                end
                SRC_POLL_NEW, SRC_POLL_HELD: begin
                    rep_len  <= p_len;
                    rep_data <= p_flat;
                end
                default: ;
            endcase
            if (src == SRC_POLL_HELD) held_v <= 1'b0;
            if (poll_take && src != SRC_POLL_NEW && (!held_v || src == SRC_POLL_HELD)) begin
                held_v    <= 1'b1;
                held_len  <= poll_len;
                held_data <= poll_data;
            end
        end
    end
endmodule

// File: rtl/host_cmd_responder.sv
module host_cmd_responder
    import rsp_pkg::*;
#(
    parameter int          IN_BYTES   = 8,
    parameter int          POLL_BYTES = 8,
    parameter int          SEC_TICKS  = 50_000_000,
    parameter logic [7:0]  RATE_RESET = 8'd20,
    localparam int IN_LW     = $clog2(IN_BYTES + 1),
    localparam int PL_W      = $clog2(POLL_BYTES + 1),
    localparam int OUT_BYTES = (POLL_BYTES + 2 > 7) ? POLL_BYTES + 2 : 7,
    localparam int OUT_LW    = $clog2(OUT_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pkt_valid,
    input  logic [IN_LW-1:0]            pkt_len,
    input  logic [IN_BYTES*8-1:0]       pkt_data,
    input  logic                        poll_valid,
    input  logic [PL_W-1:0]             poll_len,
    input  logic [POLL_BYTES*8-1:0]     poll_data,
    output logic                        rep_valid,
    output logic [OUT_LW-1:0]           rep_len,
    output logic [OUT_BYTES*8-1:0]      rep_data,
    output logic                        bus_req,
    output logic [IN_LW-1:0]            bus_len,
    output logic [(IN_BYTES-1)*8-1:0]   bus_data,
    output logic                        poll_enable,
    output logic [7:0]                  poll_period_ms,
    output logic [15:0]                 poll_mask,
    output logic                        power_off_pulse,
    output logic                        restart_pulse
);
    logic [31:0]            secs;
    logic                   cmd_has;
    logic [OUT_LW-1:0]      cmd_len;
    logic [OUT_BYTES*8-1:0] cmd_flat;
    logic                   fwd;
    effect_t                fx;
    logic                   pd_arm;
    logic                   rs_arm;

    rsp_sec_counter #(.SEC_TICKS(SEC_TICKS)) u_secs (
        .clk      (clk),
        .rst      (rst),
        .load     (fx.set_secs),
        .load_val (fx.secs),
        .secs     (secs)
    );

    rsp_cmd_decode #(
        .IN_BYTES (IN_BYTES),
        .OUT_BYTES(OUT_BYTES),
        .IN_LW    (IN_LW),
        .OUT_LW   (OUT_LW)
    ) u_dec (
        .pkt_valid(pkt_valid),
        .pkt_len  (pkt_len),
        .pkt_data (pkt_data),
        .secs     (secs),
        .has_reply(cmd_has),
        .rep_len  (cmd_len),
        .rep_flat (cmd_flat),
        .fwd      (fwd),
        .fx       (fx)
    );

    rsp_reply_sel #(
        .OUT_BYTES (OUT_BYTES),
        .OUT_LW    (OUT_LW),
        .POLL_BYTES(POLL_BYTES),
        .PL_W      (PL_W)
    ) u_sel (
        .clk      (clk),
        .rst      (rst),
        .cmd_has  (cmd_has),
        .cmd_len  (cmd_len),
        .cmd_flat (cmd_flat),
        .poll_take(poll_valid && poll_enable),
        .poll_len (poll_len),
        .poll_data(poll_data),
        .rep_valid(rep_valid),
        .rep_len  (rep_len),
        .rep_data (rep_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_enable     <= 1'b0;
            poll_period_ms  <= RATE_RESET;
            poll_mask       <= 16'hFFFF;
            pd_arm          <= 1'b0;
            rs_arm          <= 1'b0;
            power_off_pulse <= 1'b0;
            restart_pulse   <= 1'b0;
            bus_req         <= 1'b0;
            bus_len         <= '0;
            bus_data        <= '0;
        end else begin
            if (fx.set_poll_en) poll_enable    <= fx.poll_en;
            if (fx.set_rate)    poll_period_ms <= fx.rate;
            if (fx.set_mask)    poll_mask      <= fx.mask;
            pd_arm          <= fx.power_off;
            rs_arm          <= fx.restart;
            power_off_pulse <= pd_arm;
            restart_pulse   <= rs_arm;
            bus_req         <= fwd;
            if (fwd) begin
                bus_len  <= pkt_len - IN_LW'(1);
                bus_data <= pkt_data[IN_BYTES*8-1:8];
            end
        end
    end
endmodule

// File: rtl/host_cmd_responder_chk.sv
module host_cmd_responder_chk #(
    parameter int OUT_BYTES = 10,
    parameter int OUT_LW    = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rep_valid,
    input logic [OUT_LW-1:0]      rep_len,
    input logic [OUT_BYTES*8-1:0] rep_data,
    input logic                   poll_enable,
    input logic [7:0]             poll_period_ms,
    input logic [15:0]            poll_mask,
    input logic                   power_off_pulse,
    input logic                   restart_pulse
);
    p_defaults_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (poll_period_ms == 8'd20 && poll_mask == 16'hFFFF && !poll_enable && !rep_valid));

    p_class_range_r3: assert property (@(posedge clk) disable iff (rst)
        rep_valid |-> (rep_data[7:0] <= 8'h02));

    p_period_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        poll_period_ms != 8'd0);

    p_err_shape_r9: assert property (@(posedge clk) disable iff (rst)
        (rep_valid && rep_data[7:0] == 8'h02) |-> (rep_len == OUT_LW'(4) && rep_data[23:16] == 8'h01));

    p_poweroff_after_reply_r11: assert property (@(posedge clk) disable iff (rst)
        power_off_pulse |-> ($past(rep_valid) && $past(rep_data[7:0]) == 8'h01 && $past(rep_data[23:16]) == 8'h0A));

    p_restart_after_reply_r11: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |-> ($past(rep_valid) && $past(rep_data[7:0]) == 8'h01 && $past(rep_data[23:16]) == 8'h11));

    p_pulses_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(power_off_pulse && restart_pulse));

    p_poll_tag_r13: assert property (@(posedge clk) disable iff (rst)
        (rep_valid && rep_data[7:0] == 8'h00) |-> rep_data[15:8] == 8'h40);
endmodule

bind host_cmd_responder host_cmd_responder_chk #(
    .OUT_BYTES(OUT_BYTES),
    .OUT_LW   (OUT_LW)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .rep_valid      (rep_valid),
    .rep_len        (rep_len),
    .rep_data       (rep_data),
    .poll_enable    (poll_enable),
    .poll_period_ms (poll_period_ms),
    .poll_mask      (poll_mask),
    .power_off_pulse(power_off_pulse),
    .restart_pulse  (restart_pulse)
);

// File: tb/host_cmd_responder_tb_top.sv
module host_cmd_responder_tb_top;
    localparam int SEC_TICKS = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [3:0]  pkt_len = '0;
    logic [63:0] pkt_data = '0;
    logic        poll_valid = 1'b0;
    logic [3:0]  poll_len = '0;
    logic [63:0] poll_data = '0;
    logic        rep_valid;
    logic [3:0]  rep_len;
    logic [79:0] rep_data;
    logic        bus_req;
    logic [3:0]  bus_len;
    logic [55:0] bus_data;
    logic        poll_enable;
    logic [7:0]  poll_period_ms;
    logic [15:0] poll_mask;
    logic        power_off_pulse;
    logic        restart_pulse;

    always #10 clk = ~clk;

    host_cmd_responder #(.SEC_TICKS(SEC_TICKS)) dut_i (
        .clk(clk), .rst(rst),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data),
        .poll_valid(poll_valid), .poll_len(poll_len), .poll_data(poll_data),
        .rep_valid(rep_valid), .rep_len(rep_len), .rep_data(rep_data),
        .bus_req(bus_req), .bus_len(bus_len), .bus_data(bus_data),
        .poll_enable(poll_enable), .poll_period_ms(poll_period_ms), .poll_mask(poll_mask),
        .power_off_pulse(power_off_pulse), .restart_pulse(restart_pulse)
    );

    typedef struct {
        int          len;
        logic [79:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;

    function automatic logic [79:0] mkb(input logic [7:0] a0 = 0, input logic [7:0] a1 = 0,
                                        input logic [7:0] a2 = 0, input logic [7:0] a3 = 0,
                                        input logic [7:0] a4 = 0, input logic [7:0] a5 = 0,
                                        input logic [7:0] a6 = 0, input logic [7:0] a7 = 0);
        return {16'h0000, a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_rep(input string tag, input int n, input logic [79:0] d);
        exp_t e;
        e.len = n; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // drive one packet; returns at the negedge after it was taken
    task automatic send(input string tag, input int n, input logic [79:0] d, input bit replies);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_len   = 4'(n);
        pkt_data  = d[63:0];
        @(negedge clk);
        pkt_valid = 1'b0;
        check({tag, " R3 reply timing"}, {31'd0, rep_valid}, {31'd0, replies});
    endtask

    task automatic send_poll(input int n, input logic [79:0] d);
        @(negedge clk);
        poll_valid = 1'b1;
        poll_len   = 4'(n);
        poll_data  = d[63:0];
        @(negedge clk);
        poll_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t        e;
        logic [79:0] m;
        if (!rst && rep_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2 R13 unexpected reply actual len=%0d data=%h expected=none", rep_len, rep_data);
            end else begin
                e = exp_q.pop_front();
                m = '0;
                for (int i = 0; i < e.len; i++) m[8*i +: 8] = 8'hFF;
                if (rep_len !== 4'(e.len) || (rep_data & m) !== (e.data & m)) begin
                    bad++;
                    $display("FAIL %s actual len=%0d data=%h expected len=%0d data=%h",
                             e.tag, rep_len, rep_data & m, e.len, e.data & m);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 period", {24'd0, poll_period_ms}, 32'd20);
        check("R1 mask", {16'd0, poll_mask}, 32'hFFFF);
        check("R1 enable", {31'd0, poll_enable}, 32'd0);
        check("R1 idle", {29'd0, rep_valid, bus_req, power_off_pulse | restart_pulse}, 32'd0);

        // R5 set time, R4 get time
        expect_rep("R5 set time", 3, mkb(8'h01, 8'h00, 8'h09));
        send("R5", 6, mkb(8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78), 1'b1);
        expect_rep("R4 get time", 7, mkb(8'h01, 8'h00, 8'h03, 8'h12, 8'h34, 8'h56, 8'h78));
        send("R4", 2, mkb(8'h01, 8'h03), 1'b1);
        repeat (125) @(negedge clk);
        expect_rep("R5 seconds advance", 7, mkb(8'h01, 8'h00, 8'h03, 8'h12, 8'h34, 8'h56, 8'h7A));
        send("R5", 2, mkb(8'h01, 8'h03), 1'b1);

        // R6 autopoll on
        expect_rep("R6 autopoll", 3, mkb(8'h01, 8'h00, 8'h01));
        send("R6", 3, mkb(8'h01, 8'h01, 8'h01), 1'b1);
        check("R6 enable on", {31'd0, poll_enable}, 32'd1);

        // R7 rate
        expect_rep("R7 rate", 3, mkb(8'h01, 8'h00, 8'h14));
        send("R7", 3, mkb(8'h01, 8'h14, 8'h05), 1'b1);
        check("R7 period", {24'd0, poll_period_ms}, 32'd5);
        expect_rep("R7 rate zero", 4, mkb(8'h02, 8'h05, 8'h01, 8'h14));
        send("R7", 3, mkb(8'h01, 8'h14, 8'h00), 1'b1);
        check("R7 period kept", {24'd0, poll_period_ms}, 32'd5);

        // R8 mask
        expect_rep("R8 mask", 3, mkb(8'h01, 8'h00, 8'h19));
        send("R8", 4, mkb(8'h01, 8'h19, 8'hAB, 8'hCD), 1'b1);
        check("R8 mask value", {16'd0, poll_mask}, 32'hABCD);

        // R9 wrong counts
        expect_rep("R9 short mask", 4, mkb(8'h02, 8'h05, 8'h01, 8'h19));
        send("R9", 3, mkb(8'h01, 8'h19, 8'h11), 1'b1);
        check("R9 mask kept", {16'd0, poll_mask}, 32'hABCD);
        expect_rep("R9 autopoll no arg", 4, mkb(8'h02, 8'h05, 8'h01, 8'h01));
        send("R9", 2, mkb(8'h01, 8'h01), 1'b1);
        check("R9 enable kept", {31'd0, poll_enable}, 32'd1);

        // R10 unknown
        expect_rep("R10 unknown", 4, mkb(8'h02, 8'h02, 8'h01, 8'h07));
        send("R10", 2, mkb(8'h01, 8'h07), 1'b1);

        // R12 accepted no-effect commands
        expect_rep("R12 fs flag", 3, mkb(8'h01, 8'h00, 8'h13));
        send("R12", 3, mkb(8'h01, 8'h13, 8'h01), 1'b1);
        expect_rep("R12 power msg", 3, mkb(8'h01, 8'h00, 8'h21));
        send("R12", 3, mkb(8'h01, 8'h21, 8'h00), 1'b1);
        check("R12 state kept", {poll_mask, poll_period_ms, 7'd0, poll_enable}, {16'hABCD, 8'd5, 8'd1});

        // R11 pulses
        expect_rep("R11 power off", 3, mkb(8'h01, 8'h00, 8'h0A));
        send("R11", 2, mkb(8'h01, 8'h0A), 1'b1);
        check("R11 pd not yet", {31'd0, power_off_pulse}, 32'd0);
        @(negedge clk);
        check("R11 pd pulse", {30'd0, power_off_pulse, restart_pulse}, 32'd2);
        @(negedge clk);
        check("R11 pd ends", {31'd0, power_off_pulse}, 32'd0);
        expect_rep("R11 restart", 3, mkb(8'h01, 8'h00, 8'h11));
        send("R11", 2, mkb(8'h01, 8'h11), 1'b1);
        check("R11 rs not yet", {31'd0, restart_pulse}, 32'd0);
        @(negedge clk);
        check("R11 rs pulse", {30'd0, power_off_pulse, restart_pulse}, 32'd1);
        @(negedge clk);
        check("R11 rs ends", {31'd0, restart_pulse}, 32'd0);

        // R2 bus forward and ignored classes
        send("R2", 3, mkb(8'h00, 8'hAA, 8'hBB), 1'b0);
        check("R2 bus req", {31'd0, bus_req}, 32'd1);
        check("R2 bus len", {28'd0, bus_len}, 32'd2);
        check("R2 bus data", {16'd0, bus_data[15:0]}, 32'hBBAA);
        send("R2", 3, mkb(8'h05, 8'h01, 8'h02), 1'b0);
        check("R2 odd class no req", {31'd0, bus_req}, 32'd0);
        send("R2", 1, mkb(8'h01), 1'b0);

        // R13 poll while enabled
        expect_rep("R13 poll", 4, mkb(8'h00, 8'h40, 8'h11, 8'h22));
        send_poll(2, mkb(8'h11, 8'h22));

        // R14 collision: command and poll on the same edge
        expect_rep("R14 cmd first", 3, mkb(8'h01, 8'h00, 8'h13));
        expect_rep("R14 poll second", 3, mkb(8'h00, 8'h40, 8'h33));
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = 4'd3; pkt_data = mkb(8'h01, 8'h13, 8'h00)[63:0];
        poll_valid = 1'b1; poll_len = 4'd1; poll_data = mkb(8'h33)[63:0];
        @(negedge clk);
        pkt_valid = 1'b0; poll_valid = 1'b0;
        @(negedge clk);

        // R6 off, R13 poll ignored
        expect_rep("R6 autopoll off", 3, mkb(8'h01, 8'h00, 8'h01));
        send("R6", 3, mkb(8'h01, 8'h01, 8'h00), 1'b1);
        check("R6 enable off", {31'd0, poll_enable}, 32'd0);
        send_poll(1, mkb(8'h44));
        check("R13 ignored poll", {31'd0, rep_valid}, 32'd0);

        repeat (5) @(negedge clk);
        check("R3 all replies seen", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule